// File: doc/BRIEF.md
# Robbed-Bit Signaling Debounce Monitor

This block sits behind a T1 receive framer that has already pulled the ABCD signaling nibble out of each of the 24 timeslots. At every superframe boundary the framer hands over one beat holding all 24 nibbles. A nibble that differs from the stored state is accepted only after it has arrived unchanged in two superframes in a row. Accepted values are kept in a 24-entry signaling array.

Each group of eight timeslots has a sticky change flag. Software reads the flags through a small register port, and the read clears them. An interrupt line summarises the flags that software has enabled. A freeze control holds the array and the signaling output. A substitution mode can replace the signaling output with all ones or with a user-programmed code.

The superframe input is a valid/ready stream. A beat transfers on a clock edge where both `sf_valid` and `sf_ready` are high. `sf_ready` is low while reset is asserted. After reset it stays high, so the upstream framer never sees back-pressure. The register port and the interrupt are plain signals.

Top module: `rbs_signal_monitor`

## Requirements
- R1: After reset the array holds all zeros, no change flag is set, `sig_out` is zero, `irq` is low and `sf_ready` is high.
- R2: The first superframe beat accepted after reset only loads the comparison history. It changes no array entry and sets no flag.
- R3: An array entry takes a new value only when the nibble for that timeslot is identical in two consecutive accepted beats. A beat whose nibble differs from the previous one leaves the entry unchanged.
- R4: When an array entry changes value, change flag bit g = timeslot/8 is set (bit 0 for timeslots 0-7, bit 1 for 8-15, bit 2 for 16-23). A confirmed nibble that equals the stored value sets no flag.
- R5: A read of address 0x03 returns the change flags in rdata[2:0] one cycle after `reg_rd` and clears them. If a flag is set in the same cycle as the read, the set wins. Writes to 0x03 are ignored.
- R6: While CTRL (address 0x00) bit 0 (freeze) is 1, accepted beats change no array entry. `sig_out` keeps its value, even if the substitution mode or user code is changed.
- R7: The first beat accepted after freeze is cleared only loads the history and produces no update.
- R8: CTRL bits [3:2] select what `sig_out` carries: 00 or 11 pass the array through, 01 forces every bit to one, and 10 places USER (address 0x02, bits [3:0]) in every timeslot. `sig_out` follows the array and the control registers with one cycle of latency.
- R9: `irq` = CTRL bit 1 (robbed-bit enable) AND any (flags AND MASK), where MASK is address 0x01 bits [2:0]. With CTRL bit 1 at 0, `irq` stays low while flags are set.
- R10: A read of address 0x20+t (t = 0..23) returns the stored nibble of timeslot t in rdata[3:0] one cycle after `reg_rd`. On `sf_sig` and `sig_out`, timeslot t uses bits [4t+3:4t], with A in the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | Superframe beat is valid |
| sf_ready | output | 1 | Block can accept a beat (high after reset) |
| sf_sig | input | 96 | ABCD nibbles of all 24 timeslots |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| sig_out | output | 96 | Signaling output after freeze and substitution |
| irq | output | 1 | Change interrupt |

## Verification
A history entry or primed bit in the wrong state shows up after the next beat. A nibble is then accepted one superframe early or late, and this is visible on `sig_out` one cycle later and on an array read. A stuck or wrongly cleared change flag is visible on `irq` at once and in the next read of 0x03. A broken freeze shows as `sig_out` moving during the cycles while the control bit is set. The stimulus mixes directed sequences for each rule with random beats, where each timeslot has a bias towards repeating its last value, so that confirmations and rejections both occur often.

// File: rtl/rbs_mon_pkg.sv
package rbs_mon_pkg;
  typedef enum logic [1:0] {
    SUB_PASS  = 2'b00,
    SUB_ONES  = 2'b01,
    SUB_USER  = 2'b10,
    SUB_PASSB = 2'b11
  } sub_mode_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_MASK = 1;
  localparam int unsigned REG_USER = 2;
  localparam int unsigned REG_CHG  = 3;
  localparam int unsigned REG_ARR  = 32;
endpackage

// File: rtl/rbs_sig_lane.sv
module rbs_sig_lane #(
  parameter int SIG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             flush,
  input  logic [SIG_W-1:0] rx,
  output logic [SIG_W-1:0] stored,
  output logic             changed
);
  logic [SIG_W-1:0] hist_q, stored_q;
  logic             primed_q;

  assign changed = sample_en && primed_q && (rx == hist_q) && (rx != stored_q);
  assign stored  = stored_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q   <= '0;
      stored_q <= '0;
      primed_q <= 1'b0;
    end else if (flush) begin
      primed_q <= 1'b0;
    end else if (sample_en) begin
      hist_q   <= rx;
      primed_q <= 1'b1;
      if (changed) stored_q <= rx;
    end
  end

  assert_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stored_q) |-> $past(sample_en && primed_q));
  assert_prime_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !primed_q) |=> $stable(stored_q));
endmodule

// File: rtl/rbs_chg_flags.sv
module rbs_chg_flags #(
  parameter int NGRP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] set_in,
  input  logic            rd_clr,
  input  logic [NGRP-1:0] mask,
  input  logic            rbs_en,
  output logic [NGRP-1:0] flags,
  output logic            irq
);
  logic [NGRP-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (rd_clr ? '0 : flags_q) | set_in;
  end

  assign flags = flags_q;
  assign irq   = rbs_en && |(flags_q & mask);

  assert_rur_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(|set_in)) |=> (flags_q == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    assert_set_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[g]) |-> $past(set_in[g]));
  end
endmodule

// File: rtl/rbs_sig_subst.sv
module rbs_sig_subst
  import rbs_mon_pkg::*;
#(
  parameter int NUM_TS = 24,
  parameter int SIG_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  sub_mode_e               mode,
  input  logic [SIG_W-1:0]        user,
  input  logic [NUM_TS*SIG_W-1:0] arr,
  output logic [NUM_TS*SIG_W-1:0] sig_out
);
  localparam int W = NUM_TS * SIG_W;
  logic [W-1:0] next_out, out_q;

  always_comb begin
    case (mode)
      SUB_ONES: next_out = '1;
      SUB_USER: next_out = {NUM_TS{user}};
      default:  next_out = arr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     out_q <= '0;
    else if (!hold) out_q <= next_out;
  end

  assign sig_out = out_q;

  assert_freeze_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> $stable(out_q));
endmodule

// File: rtl/rbs_signal_monitor.sv
module rbs_signal_monitor
  import rbs_mon_pkg::*;
#(
  parameter int NUM_TS = 24,
  parameter int SIG_W  = 4,
  parameter int GRP    = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sf_valid,
  output logic                    sf_ready,
  input  logic [NUM_TS*SIG_W-1:0] sf_sig,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic [NUM_TS*SIG_W-1:0] sig_out,
  output logic                    irq
);
  localparam int NGRP = NUM_TS / GRP;

  logic                    ready_q;
  logic                    freeze_q, rbs_en_q;
  sub_mode_e               mode_q;
  logic [NGRP-1:0]         mask_q;
  logic [SIG_W-1:0]        user_q;
  logic [DATA_W-1:0]       rdata_q;
  logic [NUM_TS*SIG_W-1:0] stored_flat;
  logic [NUM_TS-1:0]       changed;
  logic [NGRP-1:0]         grp_set, flags;
  logic                    sample_en, rd_clr;
  logic [ADDR_W-1:0]       arr_off;
  logic [SIG_W-1:0]        arr_sel;
  logic                    arr_hit;

  assign sf_ready  = ready_q;
  assign sample_en = sf_valid && ready_q && !freeze_q;
  assign rd_clr    = reg_rd && (reg_addr == ADDR_W'(REG_CHG));

  for (genvar t = 0; t < NUM_TS; t++) begin : g_lane
    rbs_sig_lane #(.SIG_W(SIG_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(sample_en),
      .flush    (freeze_q),
      .rx       (sf_sig[t*SIG_W +: SIG_W]),
      .stored   (stored_flat[t*SIG_W +: SIG_W]),
      .changed  (changed[t])
    );
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_set[g] = |changed[g*GRP +: GRP];
  end

  rbs_chg_flags #(.NGRP(NGRP)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_in(grp_set),
    .rd_clr(rd_clr),
    .mask  (mask_q),
    .rbs_en(rbs_en_q),
    .flags (flags),
    .irq   (irq)
  );

  rbs_sig_subst #(.NUM_TS(NUM_TS), .SIG_W(SIG_W)) u_subst (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (freeze_q),
    .mode   (mode_q),
    .user   (user_q),
    .arr    (stored_flat),
    .sig_out(sig_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      freeze_q <= 1'b0;
      rbs_en_q <= 1'b0;
      mode_q   <= SUB_PASS;
      mask_q   <= '0;
      user_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (reg_wr) begin
        if (reg_addr == ADDR_W'(REG_CTRL)) begin
          freeze_q <= reg_wdata[0];
          rbs_en_q <= reg_wdata[1];
          mode_q   <= sub_mode_e'(reg_wdata[3:2]);
        end
        if (reg_addr == ADDR_W'(REG_MASK)) mask_q <= reg_wdata[NGRP-1:0];
        if (reg_addr == ADDR_W'(REG_USER)) user_q <= reg_wdata[SIG_W-1:0];
      end
    end
  end

  assign arr_off = reg_addr - ADDR_W'(REG_ARR);

  always_comb begin
    arr_sel = '0;
    arr_hit = 1'b0;
    for (int t = 0; t < NUM_TS; t++) begin
      if (arr_off == ADDR_W'(t)) begin
        arr_sel = stored_flat[t*SIG_W +: SIG_W];
        arr_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) begin
      if (reg_addr == ADDR_W'(REG_CTRL))
        rdata_q <= DATA_W'({mode_q, rbs_en_q, freeze_q});
      else if (reg_addr == ADDR_W'(REG_MASK))
        rdata_q <= DATA_W'(mask_q);
      else if (reg_addr == ADDR_W'(REG_USER))
        rdata_q <= DATA_W'(user_q);
      else if (reg_addr == ADDR_W'(REG_CHG))
        rdata_q <= DATA_W'(flags);
      else if (arr_hit)
        rdata_q <= DATA_W'(arr_sel);
      else
        rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rbs_en_q |-> !irq);
  assert_frozen_array_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(freeze_q) |-> $stable(stored_flat));
endmodule

// File: tb/test_rbs_signal_monitor.sv
module test_rbs_signal_monitor;
  localparam int NTS = 24;
  localparam int W   = NTS * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sf_valid = 1'b0;
  logic          sf_ready;
  logic [W-1:0]  sf_sig = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [W-1:0]  sig_out;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0] m_arr [NTS];
  logic [3:0] m_hist[NTS];
  bit         m_prime[NTS];
  logic [3:0] last_sent[NTS];
  logic [2:0] m_flags = '0;
  logic [2:0] m_mask = '0;
  logic [3:0] m_user = '0;
  logic [1:0] m_mode = '0;
  bit         m_freeze = 1'b0, m_rbs = 1'b0;
  logic [W-1:0] out_exp = '0;

  rbs_signal_monitor i_rbs_signal_monitor (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_ready(sf_ready),
    .sf_sig(sf_sig), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sig_out(sig_out), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] subst_exp();
    logic [W-1:0] v;
    for (int t = 0; t < NTS; t++) begin
      case (m_mode)
        2'b01:   v[t*4 +: 4] = 4'hF;
        2'b10:   v[t*4 +: 4] = m_user;
        default: v[t*4 +: 4] = m_arr[t];
      endcase
    end
    return v;
  endfunction

  function automatic bit irq_exp();
    return m_rbs && (|(m_flags & m_mask));
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    @(posedge clk);
    @(negedge clk);
    if (!m_freeze) out_exp = subst_exp();
    check(req, sig_out, out_exp);
    check(req, W'(irq), W'(irq_exp()));
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    if (!m_freeze) out_exp = subst_exp();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      6'd0: begin
        if (d[0]) for (int t = 0; t < NTS; t++) m_prime[t] = 1'b0;
        m_freeze = d[0]; m_rbs = d[1]; m_mode = d[3:2];
      end
      6'd1: m_mask = d[2:0];
      6'd2: m_user = d[3:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic check_flags(input string req);
    logic [7:0] d;
    rd(6'd3, d);
    check(req, W'(d), W'(m_flags));
    m_flags = '0;
  endtask

  task automatic check_entry(input string req, input int t);
    logic [7:0] d;
    rd(6'(32 + t), d);
    check(req, W'(d), W'(m_arr[t]));
  endtask

  task automatic send_sf(input string req);
    logic [W-1:0] v;
    for (int t = 0; t < NTS; t++) v[t*4 +: 4] = last_sent[t];
    @(negedge clk);
    if (!m_freeze) out_exp = subst_exp();
    sf_valid = 1'b1; sf_sig = v;
    if (!m_freeze) begin
      for (int t = 0; t < NTS; t++) begin
        if (m_prime[t] && v[t*4 +: 4] == m_hist[t] && v[t*4 +: 4] != m_arr[t]) begin
          m_arr[t] = v[t*4 +: 4];
          m_flags[t/8] = 1'b1;
        end
        m_hist[t] = v[t*4 +: 4];
        m_prime[t] = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    sf_valid = 1'b0;
    check_out(req);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    for (int t = 0; t < NTS; t++) begin
      m_arr[t] = '0; m_hist[t] = '0; m_prime[t] = 1'b0; last_sent[t] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", sig_out, '0);
    check("R1", W'(irq), '0);
    check("R1", W'(sf_ready), W'(1));
    check_flags("R1");
    check_entry("R1", 5);

    wr(6'd0, 8'h02);
    wr(6'd1, 8'h07);
    // R2: first beat only primes
    last_sent[0] = 4'h5;
    send_sf("R2");
    check_entry("R2", 0);
    check_flags("R2");
    // R3/R4: second identical beat accepted
    send_sf("R3");
    check_entry("R3", 0);
    check("R9", W'(irq), W'(1));
    check_flags("R5");
    check_flags("R5");
    check("R9", W'(irq), W'(0));
    // R3: differing beats keep stored value
    last_sent[10] = 4'h3;
    send_sf("R3");
    last_sent[10] = 4'h4;
    send_sf("R3");
    check_entry("R3", 10);
    send_sf("R4");
    check_entry("R4", 10);
    // R4: confirmed equal to stored sets no flag
    check_flags("R4");
    send_sf("R4");
    check_flags("R4");
    // R9: rbs disabled masks irq
    last_sent[20] = 4'hA;
    send_sf("R9");
    send_sf("R9");
    wr(6'd0, 8'h00);
    check_out("R9");
    check_flags("R5");
    wr(6'd0, 8'h02);
    // R8: substitution modes
    wr(6'd2, 8'h09);
    wr(6'd0, 8'h06);
    check_out("R8");
    wr(6'd0, 8'h0A);
    check_out("R8");
    wr(6'd0, 8'h0E);
    check_out("R8");
    wr(6'd0, 8'h02);
    check_out("R8");
    // R6: freeze holds array and output
    wr(6'd0, 8'h03);
    last_sent[1] = 4'hC;
    send_sf("R6");
    send_sf("R6");
    check_entry("R6", 1);
    wr(6'd0, 8'h07);
    check_out("R6");
    // R7: first beat after unfreeze primes only
    wr(6'd0, 8'h02);
    check_out("R7");
    send_sf("R7");
    check_entry("R7", 1);
    send_sf("R7");
    check_entry("R7", 1);
    check_flags("R4");
    // R10: every entry readable
    for (int t = 0; t < NTS; t++) check_entry("R10", t);

    // random phase
    for (int i = 0; i < 150; i++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 4) begin
        for (int t = 0; t < NTS; t++)
          if ($urandom % 4 == 0) last_sent[t] = 4'($urandom);
        send_sf("R3");
      end else if (op == 4) begin
        check_flags("R5");
      end else if (op == 5) begin
        check_entry("R10", int'($urandom % NTS));
      end else if (op == 6) begin
        logic [7:0] c;
        c = 8'($urandom) & 8'h0E;
        if ($urandom % 5 == 0) c[0] = 1'b1;
        wr(6'd0, c);
        check_out("R6");
      end else begin
        wr(6'd1, 8'($urandom) & 8'h07);
        wr(6'd2, 8'($urandom) & 8'h0F);
        check_out("R8");
      end
    end
    wr(6'd0, 8'h02);
    for (int t = 0; t < NTS; t++) check_entry("R3", t);
    check_flags("R5");
    rd(6'd3, d);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule